// File: doc/BRIEF.md
# Buffered Pulse-Train Generator

This block produces a digital pulse train whose shape is read from a small buffer of pulse specifications. Each entry holds two tick counts: how long the output stays high and how long it then stays low. Time is measured in ticks of a timebase. The timebase is a per-clock enable taken from an internal source or from an external one. Software-side conversion from times, frequency or duty cycle into tick counts happens outside the block. The block receives ready-made counts through a simple write port while it is idle.

Two timing modes exist. In implicit mode the entries play back to back. In sample-clock mode the current entry repeats until a rising edge on the sample-clock input asks for the next one. That edge only takes effect when the running high/low cycle has finished. Either mode can play the buffer once and then stop with a done flag (finite), or wrap to the first entry forever (continuous). A stop input halts generation at any time.

Top module: `pulse_train_buf`

## Requirements
- R1: After reset the pulse output, busy, done and missed flags are all low and the buffer holds no entries.
- R2: While idle, a write appends one (high, low) entry at the end of the buffer, up to DEPTH entries. Writes to a full buffer or while busy are ignored. A clear input empties the buffer while idle and takes priority over a write in the same cycle.
- R3: A start pulse is taken only when the block is idle and the buffer is non-empty. In the next cycle busy and the pulse output are high, done and missed are low, and the mode inputs (mode_smpl = 1 selects sample-clock timing, mode_cont = 1 selects continuous) are latched for the whole run. Buffer writes and clears in the start cycle are dropped.
- R4: An entry's high phase lasts max(H,1) selected ticks and its low phase max(L,1) selected ticks. A count of zero therefore still gives a one-tick phase.
- R5: In implicit mode the entries play in write order from entry 0. The next high phase begins in the clock after the last tick of the previous low phase, with no gap.
- R6: In finite mode, the cycle that would move past the last entry ends generation instead. In the next clock busy is low, done is high and the pulse output is low. Done stays high until the next accepted start.
- R7: In continuous mode, advancing past the last entry wraps to entry 0.
- R8: In sample-clock mode, a rising edge of smpl_clk seen while busy makes one advance pending. At the end of each low phase the block advances if an advance is pending and otherwise repeats the same entry. Edges have no effect in implicit mode or while idle.
- R9: A second rising edge arriving while an advance is already pending is merged into that single advance and sets the missed flag. The flag stays set until the next accepted start.
- R10: With tb_sel = 0 the phases count tick_int enables; with tb_sel = 1 they count tick_ext enables, provided the parameter EXT_TB is set.
- R11: A stop pulse while busy makes busy and the pulse output low in the next clock without setting done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal timebase tick enable |
| tick_ext | input | 1 | External timebase tick enable |
| tb_sel | input | 1 | Timebase select, 1 = external |
| smpl_clk | input | 1 | Sample clock level, rising edges request an advance |
| start | input | 1 | Start generation |
| stop | input | 1 | Abort generation |
| mode_smpl | input | 1 | 1 = sample-clock timing, 0 = implicit |
| mode_cont | input | 1 | 1 = continuous, 0 = finite |
| wr_en | input | 1 | Append an entry |
| buf_clr | input | 1 | Empty the buffer |
| wr_high | input | CNT_W | High-phase tick count of the entry |
| wr_low | input | CNT_W | Low-phase tick count of the entry |
| pulse_out | output | 1 | Generated pulse train |
| busy | output | 1 | Generation in progress |
| done | output | 1 | Finite run completed |
| missed | output | 1 | A sample-clock edge was merged into a pending advance |

## Verification
Every control input acts on registers at a single edge. A start, stop or finishing tick therefore shows on busy, done and the pulse output one clock later. A phase boundary flips the output in the clock after the selected tick that ends it. A sample-clock edge is registered, is held as pending, and changes the output only after the current low phase ends. The missed flag rises one clock after the second edge. The bench drives inputs at the falling edge. Its behavioural model steps on the rising edge with the same inputs, and the comparison runs at the next falling edge, so every result is checked exactly one clock after the edge that causes it.

// File: rtl/pto_pkg.sv
package pto_pkg;
   typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/pto_spec_store.sv
module pto_spec_store #(
   parameter int CNT_W = 32,
   parameter int DEPTH = 8,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             clr,
   input  logic [CNT_W-1:0] wr_hi,
   input  logic [CNT_W-1:0] wr_lo,
   input  logic [IW-1:0]    hi_idx,
   input  logic [IW-1:0]    lo_idx,
   output logic [CNT_W-1:0] hi_val,
   output logic [CNT_W-1:0] lo_val,
   output logic [CW-1:0]    count
);
   localparam int SLOTS = 2 ** IW;

   logic [CNT_W-1:0] hi_mem [SLOTS];
   logic [CNT_W-1:0] lo_mem [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (wr && count < CW'(DEPTH)) begin
         count <= count + CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!clr && wr && count < CW'(DEPTH)) begin
         hi_mem[IW'(count)] <= wr_hi;
         lo_mem[IW'(count)] <= wr_lo;
      end
   end

   assign hi_val = hi_mem[hi_idx];
   assign lo_val = lo_mem[lo_idx];
endmodule

// File: rtl/pto_edge_pend.sv
module pto_edge_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic smpl_clk,
   input  logic en,
   input  logic restart,
   input  logic consume,
   output logic pend,
   output logic missed
);
   logic smpl_q;
   logic rise;

   assign rise = smpl_clk & ~smpl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smpl_q <= 1'b0;
         pend   <= 1'b0;
         missed <= 1'b0;
      end else begin
         smpl_q <= smpl_clk;
         if (restart) begin
            pend   <= 1'b0;
            missed <= 1'b0;
         end else if (!en) begin
            pend <= 1'b0;
         end else if (consume) begin
            pend <= rise;
         end else if (rise) begin
            if (pend) missed <= 1'b1;
            pend <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pto_phase_timer.sv
module pto_phase_timer #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             last
);
   logic [CNT_W-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= CNT_W'(1);
      end else if (load) begin
         rem <= load_val;
      end else if (tick && rem > CNT_W'(1)) begin
         rem <= rem - CNT_W'(1);
      end
   end

   assign last = (rem <= CNT_W'(1));
endmodule

// File: rtl/pulse_train_buf.sv
module pulse_train_buf #(
   parameter int CNT_W  = 32,
   parameter int DEPTH  = 8,
   parameter bit EXT_TB = 1'b1,
   localparam int IW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_int,
   input  logic             tick_ext,
   input  logic             tb_sel,
   input  logic             smpl_clk,
   input  logic             start,
   input  logic             stop,
   input  logic             mode_smpl,
   input  logic             mode_cont,
   input  logic             wr_en,
   input  logic             buf_clr,
   input  logic [CNT_W-1:0] wr_high,
   input  logic [CNT_W-1:0] wr_low,
   output logic             pulse_out,
   output logic             busy,
   output logic             done,
   output logic             missed
);
   import pto_pkg::*;

   if (DEPTH < 2) begin : g_bad_depth
      $error("pulse_train_buf: DEPTH must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_width
      $error("pulse_train_buf: CNT_W must be at least 2");
   end

   logic tick;
   if (EXT_TB) begin : g_tb_mux
      assign tick = tb_sel ? tick_ext : tick_int;
   end else begin : g_tb_int
      logic unused_ext;
      assign unused_ext = tick_ext ^ tb_sel;
      assign tick = tick_int;
   end

   phase_e           phase_q;
   logic [IW-1:0]    idx_q, idx_nxt;
   logic             busy_q, done_q, msm_q, mcont_q;
   logic [CW-1:0]    buf_count;
   logic [CNT_W-1:0] hi_nxt, lo_cur, load_val;
   logic             start_acc, ph_end, cyc_end, adv, at_last, finish;
   logic             pend, last, buf_wr, buf_clear;

   assign start_acc = start & ~busy_q & (buf_count != '0);
   assign ph_end    = busy_q & ~stop & tick & last;
   assign cyc_end   = ph_end & (phase_q == PH_LOW);
   assign adv       = cyc_end & (~msm_q | pend);
   assign at_last   = (CW'(idx_q) == buf_count - CW'(1));
   assign finish    = adv & at_last & ~mcont_q;
   assign buf_wr    = wr_en & ~busy_q & ~start_acc;
   assign buf_clear = buf_clr & ~busy_q & ~start_acc;

   always_comb begin
      if (start_acc)    idx_nxt = '0;
      else if (adv)     idx_nxt = at_last ? '0 : idx_q + IW'(1);
      else              idx_nxt = idx_q;
   end

   always_comb begin
      if (ph_end && phase_q == PH_HIGH)
         load_val = (lo_cur == '0) ? CNT_W'(1) : lo_cur;
      else
         load_val = (hi_nxt == '0) ? CNT_W'(1) : hi_nxt;
   end

   pto_spec_store #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (buf_wr),
      .clr    (buf_clear),
      .wr_hi  (wr_high),
      .wr_lo  (wr_low),
      .hi_idx (idx_nxt),
      .lo_idx (idx_q),
      .hi_val (hi_nxt),
      .lo_val (lo_cur),
      .count  (buf_count)
   );

   pto_edge_pend u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .smpl_clk (smpl_clk),
      .en       (busy_q & msm_q & ~stop),
      .restart  (start_acc),
      .consume  (adv & msm_q),
      .pend     (pend),
      .missed   (missed)
   );

   pto_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_acc | ph_end),
      .load_val (load_val),
      .tick     (tick & busy_q),
      .last     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         phase_q <= PH_LOW;
         idx_q   <= '0;
         msm_q   <= 1'b0;
         mcont_q <= 1'b0;
      end else begin
         idx_q <= idx_nxt;
         if (start_acc) begin
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
            phase_q <= PH_HIGH;
            msm_q   <= mode_smpl;
            mcont_q <= mode_cont;
         end else if (busy_q && stop) begin
            busy_q <= 1'b0;
         end else if (finish) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            phase_q <= PH_LOW;
         end else if (ph_end) begin
            phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
         end
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign pulse_out = busy_q & (phase_q == PH_HIGH);
endmodule

// File: rtl/pto_checks.sv
module pto_checks #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          stop,
   input logic          busy,
   input logic          pulse_out,
   input logic          done,
   input logic          missed,
   input logic [CW-1:0] count
);
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_start_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count != '0) |=> (busy && pulse_out && !done && !missed));

   assert_start_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && count == '0) |=> !busy);

   assert_finish_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(stop)) |-> (done && !pulse_out));

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_missed_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(missed) |-> $past(busy));

   assert_stop_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stop) |=> (!busy && !pulse_out && $stable(done)));
endmodule

bind pulse_train_buf pto_checks #(.DEPTH(DEPTH)) u_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .stop      (stop),
   .busy      (busy),
   .pulse_out (pulse_out),
   .done      (done),
   .missed    (missed),
   .count     (buf_count)
);

// File: tb/test_pulse_train_buf.sv
`timescale 1ns/1ps
module test_pulse_train_buf;
   localparam int CNT_W = 32;
   localparam int DEPTH = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tick_int = 1'b0, tick_ext = 1'b0, tb_sel = 1'b0, smpl_clk = 1'b0;
   logic start = 1'b0, stop = 1'b0, mode_smpl = 1'b0, mode_cont = 1'b0;
   logic wr_en = 1'b0, buf_clr = 1'b0;
   logic [CNT_W-1:0] wr_high = '0, wr_low = '0;
   logic pulse_out, busy, done, missed;

   pulse_train_buf #(.CNT_W(CNT_W), .DEPTH(DEPTH), .EXT_TB(1'b1)) i_pulse_train_buf (.*);

   always #2.5 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   string cur_req = "R1";
   int tick_mode = 0;

   // reference model state
   int q_hi[$], q_lo[$];
   bit m_busy, m_ph, m_done, m_miss, m_pend, m_prev, m_smpl, m_cont;
   int m_rem, m_idx;

   function automatic int one_min(int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_hi.delete(); q_lo.delete();
         m_busy = 0; m_ph = 0; m_done = 0; m_miss = 0; m_pend = 0; m_prev = 0;
         m_rem = 1; m_idx = 0; m_smpl = 0; m_cont = 0;
      end else begin
         bit tk, ed, consumed;
         tk = tb_sel ? tick_ext : tick_int;
         ed = smpl_clk && !m_prev;
         m_prev = smpl_clk;
         consumed = 0;
         if (!m_busy) begin
            if (start && q_hi.size() > 0) begin
               m_busy = 1; m_ph = 1; m_idx = 0; m_rem = one_min(q_hi[0]);
               m_done = 0; m_miss = 0; m_pend = 0; m_smpl = mode_smpl; m_cont = mode_cont;
            end else if (buf_clr) begin
               q_hi.delete(); q_lo.delete();
            end else if (wr_en && q_hi.size() < DEPTH) begin
               q_hi.push_back(int'(wr_high)); q_lo.push_back(int'(wr_low));
            end
         end else if (stop) begin
            m_busy = 0; m_pend = 0;
         end else begin
            if (tk) begin
               if (m_rem > 1) m_rem--;
               else if (m_ph) begin m_ph = 0; m_rem = one_min(q_lo[m_idx]); end
               else begin
                  if (!m_smpl || m_pend) begin
                     consumed = m_smpl;
                     if (m_idx == q_hi.size() - 1) begin
                        if (m_cont) m_idx = 0;
                        else begin m_busy = 0; m_done = 1; end
                     end else m_idx++;
                  end
                  m_ph = 1; m_rem = one_min(q_hi[m_idx]);
                  if (!m_busy) m_ph = 0;
               end
            end
            if (m_smpl) begin
               if (consumed) m_pend = ed;
               else if (ed) begin if (m_pend) m_miss = 1; m_pend = 1; end
            end
            if (!m_busy) m_pend = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // cycle-by-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(pulse_out === (m_busy && m_ph), cur_req, "pulse_out", int'(pulse_out), int'(m_busy && m_ph));
         chk(busy === m_busy, cur_req, "busy", int'(busy), int'(m_busy));
         chk(done === m_done, cur_req, "done", int'(done), int'(m_done));
         chk(missed === m_miss, cur_req, "missed", int'(missed), int'(m_miss));
      end
      case (tick_mode)
         0: tick_int <= 1'b1;
         1: tick_int <= (cyc % 2 == 0);
         default: tick_int <= 1'b0;
      endcase
      tick_ext <= (cyc % 3 == 0);
   end

   always @(negedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic put(input int h, input int l);
      @(negedge clk); wr_en = 1; wr_high = CNT_W'(h); wr_low = CNT_W'(l);
      @(negedge clk); wr_en = 0;
   endtask

   task automatic clear_buf();
      @(negedge clk); buf_clr = 1;
      @(negedge clk); buf_clr = 0;
   endtask

   task automatic go(input bit smpl, input bit cont);
      @(negedge clk); start = 1; mode_smpl = smpl; mode_cont = cont;
      @(negedge clk); start = 0;
   endtask

   task automatic halt();
      @(negedge clk); stop = 1;
      @(negedge clk); stop = 0;
   endtask

   task automatic edge_pulse();
      @(negedge clk); smpl_clk = 1;
      @(negedge clk); smpl_clk = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500 && busy; i++) @(negedge clk);
   endtask

   initial begin
      idle(3);
      cur_req = "R1";
      chk(pulse_out === 0 && busy === 0, "R1", "reset outputs", int'(pulse_out | busy), 0);
      chk(done === 0 && missed === 0, "R1", "reset flags", int'(done | missed), 0);
      rst_n = 1;
      idle(2);

      cur_req = "R3";   // start with an empty buffer is ignored
      go(0, 0);
      chk(busy === 0, "R3", "start on empty buffer", int'(busy), 0);

      cur_req = "R5";   // implicit finite, includes zero counts (R4)
      put(2, 3); put(0, 1); put(4, 0);
      go(0, 0);
      chk(pulse_out === 1 && busy === 1, "R3", "pulse high after start", int'(pulse_out), 1);
      put(9, 9);        // write while busy: ignored (R2)
      cur_req = "R4";
      wait_idle();
      idle(1);
      chk(done === 1 && pulse_out === 0, "R6", "finite run ends with done", int'(done), 1);

      cur_req = "R2";   // replay shows the busy-time write was dropped
      go(0, 0);
      chk(done === 0, "R3", "start clears done", int'(done), 0);
      wait_idle();
      idle(2);

      cur_req = "R7";   // continuous implicit, half-rate ticks
      tick_mode = 1;
      go(0, 1);
      idle(80);
      chk(busy === 1, "R7", "continuous still running", int'(busy), 1);
      cur_req = "R11";
      halt();
      chk(busy === 0 && done === 0 && pulse_out === 0, "R11", "stop halts without done", int'(busy | done), 0);
      tick_mode = 0;

      cur_req = "R10";  // external timebase
      tb_sel = 1;
      go(0, 0);
      wait_idle();
      idle(2);
      tb_sel = 0;

      cur_req = "R2";   // overflow and clear
      for (int k = 0; k < DEPTH + 2; k++) put(k % 3, 1);
      go(0, 0);
      wait_idle();
      idle(2);
      clear_buf();
      go(0, 0);
      chk(busy === 0, "R2", "cleared buffer refuses start", int'(busy), 0);

      cur_req = "R8";   // sample-clock continuous with merged edges
      put(3, 2); put(1, 1);
      edge_pulse();     // idle edge: no effect
      go(1, 1);
      idle(14);
      chk(busy === 1, "R8", "repeating without edge", int'(busy), 1);
      cur_req = "R9";
      edge_pulse(); edge_pulse();
      idle(1);
      chk(missed === 1, "R9", "double edge sets missed", int'(missed), 1);
      cur_req = "R8";
      for (int k = 0; k < 4; k++) begin edge_pulse(); idle(9); end
      halt();

      cur_req = "R8";   // sample-clock finite
      go(1, 0);
      chk(missed === 0, "R3", "start clears missed", int'(missed), 0);
      idle(7);
      edge_pulse(); idle(9);
      edge_pulse(); idle(9);
      cur_req = "R6";
      wait_idle();
      idle(1);
      chk(done === 1 && busy === 0, "R6", "sample finite done", int'(done), 1);

      cur_req = "R5";   // implicit with the start cycle write dropped
      @(negedge clk); start = 1; mode_smpl = 0; mode_cont = 0; wr_en = 1; wr_high = 5; wr_low = 5;
      @(negedge clk); start = 0; wr_en = 0;
      wait_idle();
      idle(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule